// File: doc/BRIEF.md
# Reset and Power Mode Controller

This block sits beside a microcontroller core and decides when the core, its peripherals and its oscillator are allowed to run, and when the rest of the chip is held in reset. It filters the raw reset pin so that only a pulse that stays high long enough, while the oscillator is running, becomes an internal reset. It also holds the two low-power modes. The core sets them through write strobes.

In sleep mode only the core clock stops. Peripherals, timers and the interrupt logic keep running, and any enabled interrupt brings the core back. In shutdown mode the oscillator itself is turned off. Only the reset pin can leave it. The pin restarts the oscillator at once, and the internal reset is released only after the oscillator reports it is stable and the full qualification time has elapsed. If both mode strobes arrive together, shutdown wins.

When the reset pin rises during sleep, the core clock comes back at once so the core can run until the internal reset takes over. For that whole window, access to internal RAM is blocked.

Top module: `rpm_ctrl`

## Requirements
- R1: After `arstN` is released, `cpuClkEn`, `periphClkEn` and `oscEn` are 1, and `intRst` and `ramBlock` are 0.
- R2: `intRst` goes high on the QUAL_CLKS-th rising edge (MC_CLKS*QUAL_MC, 24 by default) at which `rstPin` is high with the oscillator running. A shorter pin pulse never raises `intRst`. `intRst` falls on the first edge that sees `rstPin` low.
- R3: Edges at which `oscStable` is low do not count toward qualification, and they do not clear the count already reached.
- R4: A `wrIdle` strobe while running, without `wrPowerDown`, clears `cpuClkEn` on the next edge and keeps `periphClkEn` and `oscEn` at 1.
- R5: A `wrPowerDown` strobe while running clears all three enables on the next edge, whether or not `wrIdle` is also set.
- R6: In sleep mode, `intPending` sets `cpuClkEn` again on the next edge.
- R7: In shutdown mode, `intPending` has no effect. `oscEn` follows `rstPin` without waiting for a clock edge.
- R8: A reset that ends shutdown raises `intRst` only after QUAL_CLKS counted edges with `oscStable` high. The enables stay off until the edge after `intRst` rises.
- R9: A reset pin that rises in sleep mode sets `cpuClkEn` and `ramBlock` on the next edge. `ramBlock` stays high until the edge after `intRst` rises, or until `rstPin` is seen low.
- R10: While `intRst` is high, mode strobes are ignored, and the block returns to run mode.
- R11: In sleep mode, `wrPowerDown` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| arstN | input | 1 | Asynchronous power-on reset, active low |
| rstPin | input | 1 | Raw external reset pin, active high |
| wrIdle | input | 1 | Write strobe that sets the sleep bit |
| wrPowerDown | input | 1 | Write strobe that sets the shutdown bit |
| intPending | input | 1 | An enabled interrupt is pending |
| oscStable | input | 1 | Oscillator output is stable |
| cpuClkEn | output | 1 | Core clock enable |
| periphClkEn | output | 1 | Peripheral clock enable |
| oscEn | output | 1 | Oscillator enable |
| intRst | output | 1 | Qualified internal reset |
| ramBlock | output | 1 | Internal RAM access inhibit |

## Verification
The hardest situation to reach is the window in which the reset pin has risen during sleep and the internal reset has not yet fired. In that window the core runs with RAM blocked. It takes a sleep entry, then a pin pulse, followed edge by edge across the full qualification time. A second case is the shutdown exit with a late oscillator. There the stimulus holds `oscStable` low for a chosen number of edges after the pin rises. The bench sweeps pulse lengths and stability gaps, and works out the exact edge on which `intRst` must appear from the counted edges.

// File: rtl/rpm_pkg.sv
package rpm_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_PDOWN = 2'd2
  } pwrMode_t;

  // strobes from mode control to the qualification datapath
  typedef struct packed {
    logic oscRun;    // oscillator enabled and stable this cycle
    logic armBlock;  // reset pin seen while sleeping
  } ctlStrobe_t;
endpackage

// File: rtl/rpm_qual_dp.sv
module rpm_qual_dp
  import rpm_pkg::*;
#(
  parameter int MC_CLKS = 12,
  parameter int QUAL_MC = 2
) (
  input  logic       clk,
  input  logic       arstN,
  input  logic       rstPin,
  input  ctlStrobe_t strb,
  output logic       qualified,
  output logic       ramBlock
);
  localparam int QUAL_CLKS = MC_CLKS * QUAL_MC;
  localparam int CNT_W = $clog2(QUAL_CLKS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(QUAL_CLKS);

  logic [CNT_W-1:0] qualCnt;
  logic             blkFlag;

  // count edges with pin high and oscillator running; pause otherwise
  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      qualCnt <= '0;
    end else if (!rstPin) begin
      qualCnt <= '0;
    end else if (strb.oscRun && (qualCnt != CNT_MAX)) begin
      qualCnt <= qualCnt + 1'b1;
    end
  end

  assign qualified = (qualCnt == CNT_MAX);

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      blkFlag <= 1'b0;
    end else if (qualified || !rstPin) begin
      blkFlag <= 1'b0;
    end else if (strb.armBlock) begin
      blkFlag <= 1'b1;
    end
  end

  assign ramBlock = blkFlag;

  assert_qual_src_R2: assert property (@(posedge clk) disable iff (!arstN)
    $rose(qualified) |-> $past(rstPin && strb.oscRun));

  assert_cnt_pause_R3: assert property (@(posedge clk) disable iff (!arstN)
    (rstPin && !strb.oscRun) |=> $stable(qualCnt));

  assert_blk_release_R9: assert property (@(posedge clk) disable iff (!arstN)
    (blkFlag && qualified) |=> !blkFlag);
endmodule

// File: rtl/rpm_mode_ctl.sv
module rpm_mode_ctl
  import rpm_pkg::*;
(
  input  logic       clk,
  input  logic       arstN,
  input  logic       rstPin,
  input  logic       wrIdle,
  input  logic       wrPowerDown,
  input  logic       intPending,
  input  logic       oscStable,
  input  logic       qualified,
  output ctlStrobe_t strb,
  output logic       cpuClkEn,
  output logic       periphClkEn,
  output logic       oscEn
);
  pwrMode_t mode, modeNext;

  always_comb begin
    modeNext = mode;
    if (qualified) begin
      modeNext = MODE_RUN;
    end else begin
      unique case (mode)
        MODE_RUN: begin
          if (wrPowerDown)  modeNext = MODE_PDOWN;
          else if (wrIdle)  modeNext = MODE_IDLE;
        end
        MODE_IDLE: begin
          if (intPending || rstPin) modeNext = MODE_RUN;
        end
        MODE_PDOWN: modeNext = MODE_PDOWN;
        default:    modeNext = MODE_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) mode <= MODE_RUN;
    else        mode <= modeNext;
  end

  assign oscEn        = (mode != MODE_PDOWN) || rstPin;
  assign cpuClkEn     = (mode == MODE_RUN);
  assign periphClkEn  = (mode != MODE_PDOWN);
  assign strb.oscRun   = oscEn && oscStable;
  assign strb.armBlock = (mode == MODE_IDLE) && rstPin;

  assert_pd_entry_R5: assert property (@(posedge clk) disable iff (!arstN)
    (mode == MODE_RUN && wrPowerDown && !qualified) |=> (!cpuClkEn && !periphClkEn));

  assert_idle_wake_R6: assert property (@(posedge clk) disable iff (!arstN)
    (mode == MODE_IDLE && intPending) |=> cpuClkEn);

  assert_pd_hold_R7: assert property (@(posedge clk) disable iff (!arstN)
    (mode == MODE_PDOWN && !qualified) |=> !cpuClkEn);

  assert_rst_run_R10: assert property (@(posedge clk) disable iff (!arstN)
    qualified |=> (cpuClkEn && periphClkEn));
endmodule

// File: rtl/rpm_ctrl.sv
module rpm_ctrl
  import rpm_pkg::*;
#(
  parameter int MC_CLKS = 12,
  parameter int QUAL_MC = 2
) (
  input  logic clk,
  input  logic arstN,
  input  logic rstPin,
  input  logic wrIdle,
  input  logic wrPowerDown,
  input  logic intPending,
  input  logic oscStable,
  output logic cpuClkEn,
  output logic periphClkEn,
  output logic oscEn,
  output logic intRst,
  output logic ramBlock
);
  ctlStrobe_t strb;
  logic       qualified;

  rpm_mode_ctl u_ctl (
    .clk(clk), .arstN(arstN), .rstPin(rstPin), .wrIdle(wrIdle),
    .wrPowerDown(wrPowerDown), .intPending(intPending), .oscStable(oscStable),
    .qualified(qualified), .strb(strb), .cpuClkEn(cpuClkEn),
    .periphClkEn(periphClkEn), .oscEn(oscEn)
  );

  rpm_qual_dp #(.MC_CLKS(MC_CLKS), .QUAL_MC(QUAL_MC)) u_dp (
    .clk(clk), .arstN(arstN), .rstPin(rstPin), .strb(strb),
    .qualified(qualified), .ramBlock(ramBlock)
  );

  assign intRst = qualified;
endmodule

// File: tb/rpm_ctrl_tb.sv
module rpm_ctrl_tb;
  localparam int MC = 12;
  localparam int QM = 2;
  localparam int QUAL = MC * QM;

  logic clk = 1'b0;
  logic arstN = 1'b0;
  logic rstPin = 1'b0, wrIdle = 1'b0, wrPowerDown = 1'b0;
  logic intPending = 1'b0, oscStable = 1'b1;
  logic cpuClkEn, periphClkEn, oscEn, intRst, ramBlock;
  int nChk = 0, nBad = 0, cyc = 0;

  always #5 clk = ~clk;

  rpm_ctrl #(.MC_CLKS(MC), .QUAL_MC(QM)) u_dut (
    .clk(clk), .arstN(arstN), .rstPin(rstPin), .wrIdle(wrIdle),
    .wrPowerDown(wrPowerDown), .intPending(intPending), .oscStable(oscStable),
    .cpuClkEn(cpuClkEn), .periphClkEn(periphClkEn), .oscEn(oscEn),
    .intRst(intRst), .ramBlock(ramBlock)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    rstPin = 1'b1; oscStable = 1'b1;
    repeat (QUAL) step();
    rstPin = 1'b0;
    step();
  endtask

  task automatic enterMode(input logic idl, input logic pd);
    wrIdle = idl; wrPowerDown = pd;
    step();
    wrIdle = 1'b0; wrPowerDown = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    int first;
    repeat (3) step();
    arstN = 1'b1;
    step();
    // R1 reset state
    chk("R1 cpuClkEn", cpuClkEn, 1);
    chk("R1 periphClkEn", periphClkEn, 1);
    chk("R1 oscEn", oscEn, 1);
    chk("R1 intRst", intRst, 0);
    chk("R1 ramBlock", ramBlock, 0);

    // R2 pulse length sweep
    for (int len = 1; len <= QUAL + 6; len++) begin
      first = 0;
      rstPin = 1'b1;
      for (int i = 1; i <= len; i++) begin
        step();
        if (intRst && first == 0) first = i;
      end
      chk("R2 first intRst edge", first, (len >= QUAL) ? QUAL : 0);
      rstPin = 1'b0;
      step();
      chk("R2 intRst release", intRst, 0);
    end

    // R3 stability gaps pause the count
    for (int g = 1; g <= 5; g++) begin
      for (int p = 0; p <= 10; p += 5) begin
        first = 0;
        rstPin = 1'b1;
        for (int i = 1; i <= QUAL + g + 1; i++) begin
          oscStable = !(i > p && i <= p + g);
          step();
          if (intRst && first == 0) first = i;
        end
        chk("R3 first intRst edge with gap", first, QUAL + g);
        rstPin = 1'b0; oscStable = 1'b1;
        step();
      end
    end

    // R4 / R5 strobe combinations
    for (int c = 0; c < 4; c++) begin
      enterMode(c[0], c[1]);
      chk("R4/R5 cpuClkEn", cpuClkEn, (c == 0) ? 1 : 0);
      chk("R4/R5 periphClkEn", periphClkEn, (c >= 2) ? 0 : 1);
      chk("R4/R5 oscEn", oscEn, (c >= 2) ? 0 : 1);
      if (c == 1) begin
        intPending = 1'b1; step(); intPending = 1'b0;
      end else if (c >= 2) begin
        doReset();
      end
      chk("R4/R5 back to run", cpuClkEn, 1);
    end

    // R6 wake from sleep after varying delay; R11 shutdown strobe ignored
    for (int d = 1; d <= 4; d++) begin
      enterMode(1'b1, 1'b0);
      wrPowerDown = 1'b1; step(); wrPowerDown = 1'b0;
      chk("R11 periphClkEn kept in sleep", periphClkEn, 1);
      repeat (d) step();
      chk("R6 still asleep", cpuClkEn, 0);
      intPending = 1'b1; step(); intPending = 1'b0;
      chk("R6 woke", cpuClkEn, 1);
    end

    // R7 / R8 shutdown exit with late oscillator
    for (int s = 0; s <= 7; s += 7) begin
      enterMode(1'b0, 1'b1);
      intPending = 1'b1;
      repeat (3) step();
      intPending = 1'b0;
      chk("R7 interrupt ignored cpu", cpuClkEn, 0);
      chk("R7 interrupt ignored osc", oscEn, 0);
      rstPin = 1'b1; oscStable = 1'b0;
      #1;
      chk("R7 oscEn follows pin", oscEn, 1);
      first = 0;
      for (int i = 1; i <= s + QUAL; i++) begin
        oscStable = (i > s);
        step();
        if (intRst && first == 0) first = i;
      end
      chk("R8 first intRst edge", first, s + QUAL);
      chk("R8 enables still off", periphClkEn, 0);
      step();
      chk("R8 run after reset", cpuClkEn, 1);
      rstPin = 1'b0; oscStable = 1'b1;
      step();
    end

    // R9 reset during sleep, full qualification
    enterMode(1'b1, 1'b0);
    rstPin = 1'b1;
    step();
    chk("R9 core resumes", cpuClkEn, 1);
    chk("R9 ram blocked", ramBlock, 1);
    repeat (QUAL - 1) step();
    chk("R9 intRst fires", intRst, 1);
    chk("R9 ram still blocked", ramBlock, 1);
    // R10 strobe during internal reset
    wrPowerDown = 1'b1; step(); wrPowerDown = 1'b0;
    chk("R9 ram released", ramBlock, 0);
    chk("R10 strobe ignored", periphClkEn, 1);
    rstPin = 1'b0; step();

    // R9 short pin pulse during sleep
    enterMode(1'b1, 1'b0);
    rstPin = 1'b1;
    repeat (5) step();
    chk("R9 ram blocked short", ramBlock, 1);
    rstPin = 1'b0; step();
    chk("R9 ram released on pin low", ramBlock, 0);
    chk("R9 no intRst", intRst, 0);
    chk("R9 running", cpuClkEn, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule